// File: doc/BRIEF.md
# Masked Vector Lane Writeback with Scalar Broadcast

This block sits around the per-lane arithmetic of a wide vector unit. On the way in it chooses each lane's operand: either the lane's own slice of the source vector, or, when a broadcast from a memory source is requested, the lowest element copied into every lane. On the way out it takes the lane results that the arithmetic returns in the same cycle and merges them into the prior destination under a per-lane write mask. Masked-off lanes either keep their old contents or are cleared, depending on a mode select. A mask-enable input of 0 makes every lane active.

The arithmetic reports exception flags per lane. Only lanes that are active contribute to the ORed flag output. The new destination, the lane-active vector and the ORed flags are registered, and they appear one cycle after a valid input together with an output-valid pulse.

Top module: `vlane_wb`

## Requirements
- R1: Lane j occupies bits [j*LANE_W+LANE_W-1 : j*LANE_W] of every vector port. Without a memory broadcast, operand lane j equals source lane j. This is combinational.
- R2: When `bcast_sel`=1 and `src_is_mem`=1, every operand lane equals source bits [LANE_W-1:0].
- R3: When `bcast_sel`=1 and `src_is_mem`=0, the broadcast has no effect and each lane uses its own source slice.
- R4: When `mask_en`=0, every lane of the destination takes its new result and `lane_act` is all ones, whatever `mask` holds.
- R5: When `mask_en`=1 and `zero_mode`=0, a lane whose mask bit is 0 keeps its `old_dst` value.
- R6: When `mask_en`=1 and `zero_mode`=1, a lane whose mask bit is 0 is written with all zeros.
- R7: When `mask_en`=1, `lane_act` equals `mask`, and lanes whose mask bit is 1 take their new result.
- R8: `flags_or` is the bitwise OR of the FLAG_W-bit flag groups of active lanes only. Lane j's group is `res_flags` bits [j*FLAG_W+FLAG_W-1 : j*FLAG_W].
- R9: `dst_vec`, `lane_act` and `flags_or` update at the clock edge that samples `in_valid`=1, and `out_valid` is high for exactly the following cycle. Without `in_valid`, the registered outputs hold their values and `out_valid` is 0.
- R10: Synchronous active-high reset clears `out_valid`, `dst_vec`, `lane_act` and `flags_or`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand and result inputs are valid this cycle |
| src_vec | input | LANES*LANE_W | Source vector |
| bcast_sel | input | 1 | Broadcast requested |
| src_is_mem | input | 1 | Source comes from memory |
| opnd_vec | output | LANES*LANE_W | Per-lane operands to the arithmetic |
| res_vec | input | LANES*LANE_W | Per-lane results from the arithmetic |
| res_flags | input | LANES*FLAG_W | Per-lane exception flags |
| old_dst | input | LANES*LANE_W | Prior destination value |
| mask | input | LANES | Per-lane write mask |
| mask_en | input | 1 | 1 = mask in use, 0 = all lanes active |
| zero_mode | input | 1 | 1 = clear masked-off lanes, 0 = keep them |
| out_valid | output | 1 | Registered outputs are new this cycle |
| dst_vec | output | LANES*LANE_W | New destination vector |
| lane_act | output | LANES | Lanes written with a new result |
| flags_or | output | FLAG_W | OR of the active lanes' flags |

## Verification
The bench builds the block with LANES=4, LANE_W=8 and FLAG_W=2. With these values all 16 masks can be swept against every combination of broadcast, memory source, mask enable and zero mode. Each lane result and flag group is random, so a lane taken from the wrong source, a wrong merge or a leaking flag shows up in a value the bench computes itself. The same sweep reaches the broadcast path whose lane-0 slice differs from the other lanes, and the all-zero and all-one masks.

// File: rtl/vlane_pkg.sv
package vlane_pkg;
  typedef enum logic {WB_MERGE = 1'b0, WB_ZERO = 1'b1} wb_mode_e;

  function automatic logic lane_on(input logic mbit, input logic men);
    return mbit | ~men;
  endfunction
endpackage

// File: rtl/vlane_opsel.sv
module vlane_opsel #(
  parameter int LANES  = 8,
  parameter int LANE_W = 64,
  localparam int VW = LANES * LANE_W
) (
  input  logic [VW-1:0] src_vec,
  input  logic          bcast_sel,
  input  logic          src_is_mem,
  output logic [VW-1:0] opnd_vec
);
  logic use_scalar;
  assign use_scalar = bcast_sel & src_is_mem;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign opnd_vec[j*LANE_W +: LANE_W] =
      use_scalar ? src_vec[LANE_W-1:0] : src_vec[j*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/vlane_merge.sv
module vlane_merge
  import vlane_pkg::*;
#(
  parameter int LANE_W = 64
) (
  input  logic              mbit,
  input  logic              mask_en,
  input  wb_mode_e          mode,
  input  logic [LANE_W-1:0] res,
  input  logic [LANE_W-1:0] old,
  output logic [LANE_W-1:0] nxt,
  output logic              act
);
  always_comb begin
    act = lane_on(mbit, mask_en);
    if (act)                  nxt = res;
    else if (mode == WB_ZERO) nxt = '0;
    else                      nxt = old;
  end
endmodule

// File: rtl/vlane_flagor.sv
module vlane_flagor #(
  parameter int LANES  = 8,
  parameter int FLAG_W = 2
) (
  input  logic [LANES*FLAG_W-1:0] flags,
  input  logic [LANES-1:0]        act,
  output logic [FLAG_W-1:0]       merged
);
  always_comb begin
    merged = '0;
    for (int j = 0; j < LANES; j++)
      if (act[j]) merged |= flags[j*FLAG_W +: FLAG_W];
  end
endmodule

// File: rtl/vlane_wb.sv
module vlane_wb
  import vlane_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int LANE_W = 64,
  parameter int FLAG_W = 2,
  localparam int VW = LANES * LANE_W,
  localparam int FW = LANES * FLAG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [VW-1:0]     src_vec,
  input  logic              bcast_sel,
  input  logic              src_is_mem,
  output logic [VW-1:0]     opnd_vec,
  input  logic [VW-1:0]     res_vec,
  input  logic [FW-1:0]     res_flags,
  input  logic [VW-1:0]     old_dst,
  input  logic [LANES-1:0]  mask,
  input  logic              mask_en,
  input  logic              zero_mode,
  output logic              out_valid,
  output logic [VW-1:0]     dst_vec,
  output logic [LANES-1:0]  lane_act,
  output logic [FLAG_W-1:0] flags_or
);
  logic [VW-1:0]     nxt_dst;
  logic [LANES-1:0]  nxt_act;
  logic [FLAG_W-1:0] nxt_flags;
  wb_mode_e          mode;

  assign mode = wb_mode_e'(zero_mode);

  vlane_opsel #(.LANES(LANES), .LANE_W(LANE_W)) u_opsel (
    .src_vec(src_vec), .bcast_sel(bcast_sel), .src_is_mem(src_is_mem),
    .opnd_vec(opnd_vec)
  );

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    vlane_merge #(.LANE_W(LANE_W)) u_merge (
      .mbit(mask[j]), .mask_en(mask_en), .mode(mode),
      .res(res_vec[j*LANE_W +: LANE_W]), .old(old_dst[j*LANE_W +: LANE_W]),
      .nxt(nxt_dst[j*LANE_W +: LANE_W]), .act(nxt_act[j])
    );
  end

  vlane_flagor #(.LANES(LANES), .FLAG_W(FLAG_W)) u_flagor (
    .flags(res_flags), .act(nxt_act), .merged(nxt_flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      dst_vec   <= '0;
      lane_act  <= '0;
      flags_or  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        dst_vec  <= nxt_dst;
        lane_act <= nxt_act;
        flags_or <= nxt_flags;
      end
    end
  end
endmodule

// File: rtl/vlane_wb_chk.sv
module vlane_wb_chk #(
  parameter int LANES  = 8,
  parameter int LANE_W = 64,
  parameter int FLAG_W = 2,
  localparam int VW = LANES * LANE_W,
  localparam int FW = LANES * FLAG_W
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [VW-1:0]     src_vec,
  input logic              bcast_sel,
  input logic              src_is_mem,
  input logic [VW-1:0]     opnd_vec,
  input logic [VW-1:0]     old_dst,
  input logic [LANES-1:0]  mask,
  input logic              mask_en,
  input logic              zero_mode,
  input logic              out_valid,
  input logic [VW-1:0]     dst_vec,
  input logic [LANES-1:0]  lane_act,
  input logic [FLAG_W-1:0] flags_or
);
  p_valid_r9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(dst_vec) && $stable(lane_act)));
  p_reset_r10: assert property (@(posedge clk)
    rst |=> (!out_valid && dst_vec == '0 && lane_act == '0));
  p_nomask_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !mask_en) |=> (lane_act == {LANES{1'b1}}));
  p_mask_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mask_en) |=> (lane_act == $past(mask)));
  p_noflag_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && lane_act == '0) |-> (flags_or == '0));

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    p_bcast_r2: assert property (@(posedge clk) disable iff (rst)
      (bcast_sel && src_is_mem) |->
        (opnd_vec[j*LANE_W +: LANE_W] == src_vec[LANE_W-1:0]));
    p_own_r1: assert property (@(posedge clk) disable iff (rst)
      !(bcast_sel && src_is_mem) |->
        (opnd_vec[j*LANE_W +: LANE_W] == src_vec[j*LANE_W +: LANE_W]));
    p_keep_r5: assert property (@(posedge clk) disable iff (rst)
      (in_valid && mask_en && !zero_mode && !mask[j]) |=>
        (dst_vec[j*LANE_W +: LANE_W] == $past(old_dst[j*LANE_W +: LANE_W])));
    p_clear_r6: assert property (@(posedge clk) disable iff (rst)
      (in_valid && mask_en && zero_mode && !mask[j]) |=>
        (dst_vec[j*LANE_W +: LANE_W] == '0));
  end
endmodule

bind vlane_wb vlane_wb_chk #(.LANES(LANES), .LANE_W(LANE_W), .FLAG_W(FLAG_W)) u_chk (.*);

// File: tb/tb_vlane_wb.sv
`timescale 1ns/1ps
module tb_vlane_wb;
  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int FLAG_W = 2;
  localparam int VW = LANES * LANE_W;
  localparam int FW = LANES * FLAG_W;

  logic              clk = 1'b0;
  logic              rst;
  logic              in_valid;
  logic [VW-1:0]     src_vec, res_vec, old_dst, opnd_vec, dst_vec;
  logic [FW-1:0]     res_flags;
  logic              bcast_sel, src_is_mem, mask_en, zero_mode, out_valid;
  logic [LANES-1:0]  mask, lane_act;
  logic [FLAG_W-1:0] flags_or;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  vlane_wb #(.LANES(LANES), .LANE_W(LANE_W), .FLAG_W(FLAG_W)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src_vec(src_vec),
    .bcast_sel(bcast_sel), .src_is_mem(src_is_mem), .opnd_vec(opnd_vec),
    .res_vec(res_vec), .res_flags(res_flags), .old_dst(old_dst),
    .mask(mask), .mask_en(mask_en), .zero_mode(zero_mode),
    .out_valid(out_valid), .dst_vec(dst_vec), .lane_act(lane_act),
    .flags_or(flags_or)
  );

  task automatic check(input string req, input logic [VW-1:0] got, input logic [VW-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [VW-1:0]     e_op, e_dst, hold_dst;
    logic [LANES-1:0]  e_act;
    logic [FLAG_W-1:0] e_flg;
    rst = 1'b1; in_valid = 1'b0; src_vec = '0; res_vec = '0; old_dst = '0;
    res_flags = '0; bcast_sel = 1'b0; src_is_mem = 1'b0; mask = '0;
    mask_en = 1'b0; zero_mode = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R10 out_valid", VW'(out_valid), '0);
    check("R10 dst_vec", dst_vec, '0);
    check("R10 lane_act", VW'(lane_act), '0);
    check("R10 flags_or", VW'(flags_or), '0);
    @(negedge clk) rst = 1'b0;

    for (int bc = 0; bc < 2; bc++)
      for (int mem = 0; mem < 2; mem++)
        for (int men = 0; men < 2; men++)
          for (int zm = 0; zm < 2; zm++)
            for (int m = 0; m < (1 << LANES); m++) begin
              @(negedge clk);
              in_valid = 1'b1; bcast_sel = bc[0]; src_is_mem = mem[0];
              mask_en = men[0]; zero_mode = zm[0]; mask = m[LANES-1:0];
              src_vec = $urandom; res_vec = $urandom; old_dst = $urandom;
              res_flags = FW'($urandom);
              e_flg = '0;
              for (int j = 0; j < LANES; j++) begin
                logic on;
                e_op[j*LANE_W +: LANE_W] = (bc == 1 && mem == 1) ?
                  src_vec[LANE_W-1:0] : src_vec[j*LANE_W +: LANE_W];
                on = (men == 0) || m[j];
                e_act[j] = on;
                if (on) begin
                  e_dst[j*LANE_W +: LANE_W] = res_vec[j*LANE_W +: LANE_W];
                  e_flg |= res_flags[j*FLAG_W +: FLAG_W];
                end else if (zm == 1) e_dst[j*LANE_W +: LANE_W] = '0;
                else e_dst[j*LANE_W +: LANE_W] = old_dst[j*LANE_W +: LANE_W];
              end
              #1;
              if (bc == 1 && mem == 1) check("R2 broadcast operand", opnd_vec, e_op);
              else if (bc == 1)        check("R3 broadcast ignored", opnd_vec, e_op);
              else                     check("R1 lane operand", opnd_vec, e_op);
              @(posedge clk); #1;
              check("R9 out_valid", VW'(out_valid), VW'(1));
              if (men == 0)     check("R4 nomask dst", dst_vec, e_dst);
              else if (zm == 0) check("R5 merge dst", dst_vec, e_dst);
              else              check("R6 zero dst", dst_vec, e_dst);
              if (men == 0) check("R4 lane_act", VW'(lane_act), VW'(e_act));
              else          check("R7 lane_act", VW'(lane_act), VW'(e_act));
              check("R8 flags_or", VW'(flags_or), VW'(e_flg));
            end

    @(negedge clk);
    hold_dst = dst_vec;
    in_valid = 1'b0; res_vec = ~res_vec; old_dst = ~old_dst; mask_en = 1'b0;
    res_flags = '1;
    @(posedge clk); #1;
    check("R9 idle out_valid", VW'(out_valid), '0);
    check("R9 idle hold dst", dst_vec, hold_dst);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule